// File: doc/BRIEF.md
# I2C Serial Clock Rate Generator

This block derives the serial-clock timing of an I2C master from a fast baud-rate clock. The clock passes through two dividers in series. The first is a power-of-two prescaler whose ratio comes from a 2-bit field. The second is an 8-bit programmable divider whose effective count carries a fixed offset of three, and two more when the digital-filter bit is set.

For each half period of the serial clock, the block emits a one-cycle pulse. It also drives a level that toggles on every such pulse, which a bit engine can use as its SCL-rate phase.

Software programs the block through two write ports: a mode word and a divider word. New values are held until the running half period ends, so a reconfiguration never shortens or stretches the current half period. Writes made while the block is disabled apply from the moment it is enabled.

Top module: `i2c_scl_rate_gen`

## Requirements
- R1: The prescale field sits at mode bits [2:1] and selects the first-stage ratio 32 >> field, so values 0, 1, 2 and 3 give 32, 16, 8 and 4.
- R2: One half period lasts divider + 3 + 2·filter prescaled cycles. The filter bit sits at mode bit 3 and the divider takes values 0 to 255.
- R3: Consecutive `half_tick` pulses are prescale × (divider + 3 + 2·filter) system clocks apart. After the edge that captures an enabling mode write, the first pulse is seen that many cycles later.
- R4: The enable is mode bit 0. While it is 0, both counters are held cleared, `half_tick` stays low and `scl_en` stays low. Clearing it in the middle of a half period stops all further pulses.
- R5: Only the low 8 bits of a divider write are kept. Bits [15:8] of `div_wdata` have no effect on the tick period.
- R6: A mode or divider write made while the block is running completes the current half period with the old setting. The new setting governs every half period after that.
- R7: `half_tick` is high for exactly one system clock cycle at each half-period boundary.
- R8: `scl_en` is low when the block is enabled, toggles in the cycle after every `half_tick`, and is therefore high and low for one half period each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Baud-rate/system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the mode word |
| mode_wdata | input | 8 | Mode word: bit 0 enable, bits [2:1] prescale, bit 3 filter |
| div_wr | input | 1 | Write strobe for the divider word |
| div_wdata | input | 16 | Divider word; only bits [7:0] are kept |
| half_tick | output | 1 | One-cycle pulse at each SCL half-period boundary |
| scl_en | output | 1 | SCL-rate phase level, toggling on every half tick |

## Verification
The bench builds the block with its default parameters: an 8-bit divider, a 2-bit prescale field with a largest shift of five, and a 16-bit divider write port. This places every prescale setting, both divider extremes and both filter states inside one run. The longest half period (prescale 32, divider 255, filter set) is 8320 cycles, so three such intervals stay far below the cycle limit. The 16-bit write port leaves eight upper bits to prove that they are discarded. The short settings let the bench change the mode and the divider several times in the middle of a half period and observe, at the tick output, exactly when each new value takes hold.

// File: rtl/brg_pkg.sv
// Package: shared widths, bit positions and the configuration record for
// the serial clock rate generator. Assumes the mode word is at least
// FILT_BIT+1 bits wide and the divider write port is wider than DIV_W.
package brg_pkg;
    localparam int DIV_W     = 8;   // divider register width
    localparam int PS_W      = 2;   // prescale field width
    localparam int MAX_SHIFT = 5;   // prescale field 0 divides by 2**MAX_SHIFT
    localparam int BASE_OFS  = 3;   // fixed offset added to the divider
    localparam int FILT_OFS  = 2;   // extra offset when filtering is enabled
    localparam int MODE_W    = 8;   // mode write port width
    localparam int WDATA_W   = 16;  // divider write port width
    localparam int EN_BIT    = 0;   // enable position in the mode word
    localparam int PS_LSB    = 1;   // prescale field low bit in the mode word
    localparam int FILT_BIT  = 3;   // filter enable position in the mode word

    typedef struct packed {
        logic             en;
        logic             filt;
        logic [PS_W-1:0]  ps;
        logic [DIV_W-1:0] div;
    } brg_cfg_t;
endpackage

// File: rtl/brg_cfg_regs.sv
// Module: programmed configuration registers. Decodes the mode word and
// keeps only the low bits of the divider word. cfg_d is the value the
// registers take at the next edge, which lets the stages load a setting
// in the same edge that it is written. Assumes writes are single-cycle.
module brg_cfg_regs
    import brg_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int WW = WDATA_W,
    parameter int MW = MODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr,
    input  logic [MW-1:0] mode_wdata,
    input  logic          div_wr,
    input  logic [WW-1:0] div_wdata,
    output brg_cfg_t      cfg_q,
    output brg_cfg_t      cfg_d
);
    logic unused_hi_bits;
    assign unused_hi_bits = ^{mode_wdata[MW-1:FILT_BIT+1], div_wdata[WW-1:DW]};

    // Next configuration: apply whichever write strobes are active.
    always_comb begin
        cfg_d = cfg_q;
        if (mode_wr) begin
            cfg_d.en   = mode_wdata[EN_BIT];
            cfg_d.ps   = mode_wdata[PS_LSB +: PS_W];
            cfg_d.filt = mode_wdata[FILT_BIT];
        end
        if (div_wr) begin
            cfg_d.div = div_wdata[DW-1:0];
        end
    end

    // Hold the programmed configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    p_div_low_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> (cfg_q.div == $past(div_wdata[DW-1:0])));
endmodule

// File: rtl/brg_prescaler.sv
// Module: first stage, a power-of-two prescaler dividing by
// 2**(MAX_SHIFT - ps). The active ratio reloads while idle or at a
// half-period boundary (reload), when the counter also wraps, so a
// ratio change never produces a partial prescale period.
// Assumes ps never exceeds MAX_SHIFT.
module brg_prescaler
    import brg_pkg::*;
#(
    parameter int PSW = PS_W,
    parameter int MSH = MAX_SHIFT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           idle,
    input  logic           reload,
    input  logic [PSW-1:0] ps_in,
    output logic           pre_tick
);
    localparam int PCNT_W = MSH;
    localparam int SH_W   = $clog2(MSH + 1);

    logic [PSW-1:0]    act_ps;
    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] lim;
    logic [PCNT_W:0]   span;
    logic [SH_W-1:0]   sh;

    // Terminal count of the prescaler for the active ratio.
    always_comb begin
        sh   = SH_W'(MSH) - SH_W'(act_ps);
        span = (PCNT_W + 1)'(1) << sh;
        lim  = PCNT_W'(span - 1'b1);
    end

    assign pre_tick = !idle && (pcnt == lim);

    // Active ratio: follow the programmed value while idle, else at reload.
    always_ff @(posedge clk) begin
        if (!rst_n)              act_ps <= '0;
        else if (idle || reload) act_ps <= ps_in;
    end

    // Prescale counter: cleared when stopped, wraps at its terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)            pcnt <= '0;
        else if (!run || idle) pcnt <= '0;
        else if (pcnt == lim)  pcnt <= '0;
        else                   pcnt <= pcnt + 1'b1;
    end

    p_pcnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= lim);
    p_ratio_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !$past(idle) && !$past(reload)) |-> $stable(act_ps));
endmodule

// File: rtl/brg_half_div.sv
// Module: second stage. Counts prescaled ticks up to
// div + BASE_OFS + FILT_OFS*filt per half period, pulses half_tick at the
// end of each one and toggles the SCL phase. The divider and the filter
// reload only while idle or at the half-period boundary.
// Assumes pre_tick is a one-cycle strobe that is low while idle.
module brg_half_div
    import brg_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          idle,
    input  logic          pre_tick,
    input  logic [DW-1:0] div_in,
    input  logic          filt_in,
    output logic          half_tick,
    output logic          scl_q
);
    localparam int NCNT_W = DW + 1;

    logic [DW-1:0]     act_div;
    logic              act_filt;
    logic [NCNT_W-1:0] dcnt;
    logic [NCNT_W-1:0] nlim;

    // Last count value of one half period.
    always_comb begin
        nlim = NCNT_W'(act_div) + NCNT_W'(BASE_OFS - 1)
             + (act_filt ? NCNT_W'(FILT_OFS) : '0);
    end

    assign half_tick = pre_tick && (dcnt == nlim);

    // Active divider and filter: follow while idle, else reload at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_div  <= '0;
            act_filt <= 1'b0;
        end else if (idle || half_tick) begin
            act_div  <= div_in;
            act_filt <= filt_in;
        end
    end

    // Half-period counter: advances on each prescaled tick.
    always_ff @(posedge clk) begin
        if (!rst_n)            dcnt <= '0;
        else if (!run || idle) dcnt <= '0;
        else if (pre_tick)     dcnt <= (dcnt == nlim) ? '0 : dcnt + 1'b1;
    end

    // SCL phase: low when stopped, flips at every half-period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)         scl_q <= 1'b0;
        else if (!run)      scl_q <= 1'b0;
        else if (half_tick) scl_q <= ~scl_q;
    end

    p_dcnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dcnt <= nlim);
    p_div_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !$past(idle) && !$past(half_tick)) |-> ($stable(act_div) && $stable(act_filt)));
    p_tick_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick |=> !half_tick);
    p_scl_flips_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !idle && $past(half_tick) && $past(run)) |-> (scl_q != $past(scl_q)));
endmodule

// File: rtl/i2c_scl_rate_gen.sv
// Module: top of the serial clock rate generator. The configuration
// registers feed the prescaler and the half-period divider. The stages
// run while the registered enable and its next value are both set, and
// take new settings at the half-period boundary. Assumes a single clock
// domain and single-cycle write strobes.
module i2c_scl_rate_gen
    import brg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_wr,
    input  logic [MODE_W-1:0]  mode_wdata,
    input  logic               div_wr,
    input  logic [WDATA_W-1:0] div_wdata,
    output logic               half_tick,
    output logic               scl_en
);
    brg_cfg_t cfg_q;
    brg_cfg_t cfg_d;
    logic     run;
    logic     idle;
    logic     pre_tick;

    assign run  = cfg_d.en;
    assign idle = !cfg_q.en;

    brg_cfg_regs #(.DW(DIV_W), .WW(WDATA_W), .MW(MODE_W)) i_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .div_wr     (div_wr),
        .div_wdata  (div_wdata),
        .cfg_q      (cfg_q),
        .cfg_d      (cfg_d)
    );

    brg_prescaler #(.PSW(PS_W), .MSH(MAX_SHIFT)) i_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .idle     (idle),
        .reload   (half_tick),
        .ps_in    (cfg_d.ps),
        .pre_tick (pre_tick)
    );

    brg_half_div #(.DW(DIV_W)) i_half (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .idle      (idle),
        .pre_tick  (pre_tick),
        .div_in    (cfg_d.div),
        .filt_in   (cfg_d.filt),
        .half_tick (half_tick),
        .scl_q     (scl_en)
    );

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.en |-> (!half_tick && !scl_en));
endmodule

// File: tb/test_i2c_scl_rate_gen.sv
// Scoreboard bench: the driver pushes expected tick intervals into a queue,
// and the monitor pops one at every half_tick and compares it with the
// measured interval. Inputs change 2 ns after a rising edge; outputs are
// sampled on the falling edge.
module test_i2c_scl_rate_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [7:0]  mode_wdata = '0;
    logic        div_wr = 1'b0;
    logic [15:0] div_wdata = '0;
    logic        half_tick;
    logic        scl_en;

    int    n_chk = 0;
    int    n_fail = 0;
    int    exp_q[$];
    string cur_req = "R3";
    int    off_ticks = 0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    i2c_scl_rate_gen i_i2c_scl_rate_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .div_wr     (div_wr),
        .div_wdata  (div_wdata),
        .half_tick  (half_tick),
        .scl_en     (scl_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int half_len(input int ps, input int f, input int d);
        return (32 >> ps) * (d + 3 + 2 * f);
    endfunction

    task automatic wr_mode(input bit en, input bit f, input int ps);
        @(posedge clk); #2;
        mode_wr = 1'b1;
        mode_wdata = {4'b0, f, 2'(ps), en};
        @(posedge clk); #2;
        mode_wr = 1'b0;
    endtask

    task automatic wr_div(input logic [15:0] v);
        @(posedge clk); #2;
        div_wr = 1'b1;
        div_wdata = v;
        @(posedge clk); #2;
        div_wr = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
    endtask

    task automatic run_cfg(input int ps, input bit f, input logic [15:0] dv, input int nt);
        wr_mode(1'b0, 1'b0, 0);
        wr_div(dv);
        for (int i = 0; i < nt; i++) exp_q.push_back(half_len(ps, f, int'(dv[7:0])));
        wr_mode(1'b1, f, ps);
        drain();
        wr_mode(1'b0, 1'b0, 0);
    endtask

    // Monitor: tracks the enable seen by the design and checks every tick.
    bit en_live = 1'b0, en_next = 1'b0, en_prev, exp_scl = 1'b0, prev_tick = 1'b0;
    int cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            en_live = 1'b0; en_next = 1'b0; cnt = 0; exp_scl = 1'b0; prev_tick = 1'b0;
        end else begin
            en_prev = en_live;
            en_live = en_next;
            if (en_live && !en_prev) cnt = 1;
            else cnt = cnt + 1;
            if (half_tick) begin
                if (!en_live) begin
                    off_ticks++;
                    chk(1'b0, "R4", "tick while disabled", 1, 0);
                end else if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected tick after interval", cnt, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(cnt == e, cur_req, "tick interval", cnt, e);
                end
                chk(!prev_tick, "R7", "tick wider than one cycle", int'(prev_tick), 0);
                chk(scl_en == exp_scl, "R8", "scl_en phase at tick", int'(scl_en), int'(exp_scl));
                exp_scl = ~exp_scl;
                cnt = 0;
            end
            if (!en_live) exp_scl = 1'b0;
            prev_tick = half_tick;
            if (mode_wr) en_next = mode_wdata[0];
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(half_tick == 1'b0, "R4", "reset half_tick", int'(half_tick), 0);
        chk(scl_en == 1'b0, "R4", "reset scl_en", int'(scl_en), 0);

        // R1: all four prescale settings with the smallest divider
        cur_req = "R1";
        for (int ps = 0; ps < 4; ps++) run_cfg(ps, 1'b0, 16'd0, 3);

        // R2: divider extremes and the filter bit both ways
        cur_req = "R2";
        run_cfg(3, 1'b1, 16'd0, 3);
        run_cfg(3, 1'b0, 16'd255, 3);
        run_cfg(0, 1'b1, 16'd255, 2);
        run_cfg(2, 1'b1, 16'd7, 3);
        run_cfg(1, 1'b0, 16'd100, 2);

        // R5: upper divider bits carry no weight
        cur_req = "R5";
        run_cfg(3, 1'b0, 16'hAB00, 3);
        run_cfg(3, 1'b0, 16'hFF05, 3);

        // R6: reconfiguration in the middle of a half period
        cur_req = "R6";
        wr_mode(1'b0, 1'b0, 0);
        wr_div(16'd0);
        for (int i = 0; i < 3; i++) exp_q.push_back(half_len(3, 0, 0));
        wr_mode(1'b1, 1'b0, 3);
        while (exp_q.size() != 1) @(posedge clk);
        repeat (3) @(posedge clk);
        for (int i = 0; i < 4; i++) exp_q.push_back(half_len(2, 1, 0));
        wr_mode(1'b1, 1'b1, 2);
        while (exp_q.size() != 1) @(posedge clk);
        repeat (5) @(posedge clk);
        for (int i = 0; i < 3; i++) exp_q.push_back(half_len(2, 1, 9));
        wr_div(16'd9);
        drain();
        wr_mode(1'b0, 1'b0, 0);

        // R4: disable mid-period, then idle with a write made while off
        cur_req = "R4";
        wr_div(16'd0);
        exp_q.push_back(half_len(3, 0, 0));
        wr_mode(1'b1, 1'b0, 3);
        drain();
        repeat (4) @(posedge clk);
        wr_mode(1'b0, 1'b0, 3);
        wr_div(16'd1);
        repeat (300) @(posedge clk);
        @(negedge clk);
        chk(scl_en == 1'b0, "R4", "scl_en while disabled", int'(scl_en), 0);
        chk(off_ticks == 0, "R4", "ticks while disabled", off_ticks, 0);
        chk(exp_q.size() == 0, "R3", "expected ticks left over", exp_q.size(), 0);

        repeat (5) @(posedge clk);
        finish_run();
    end
endmodule